// File: doc/BRIEF.md
# Burst Target Address Tracker

This block is the target side of a shared, multiplexed address/data bus. It watches for the initiator to open a transaction. It captures the start address and command in the single clock where they are valid, and checks them against a programmable window. On a hit it claims the transaction. It then walks a beat address forward for each data beat that completes, and hands the address, write data and byte enables to a local backend.

The backend answers with read data and a ready flag. While ready is low, the target holds off its own ready output, so every beat can be stretched by wait states. A parameter builds the block as a single-beat target instead. In that case it asks for a disconnect during the first data beat and releases the bus after that beat, whatever burst length the initiator intended. The bus-side handshakes are active-high in this block. Pad inversion is left to the surrounding logic.

Top module: `burst_target_tracker`

## Requirements
- R1: While `rstN` is low, `tgtSelect`, `tgtReady`, `tgtStop`, `beBeat`, `beWrite` and `beRead` are low, and the block returns to its idle state.
- R2: The address phase is a clock in which `busCycle` is high while the block is idle. `busAd` and `busCmd` are captured at the end of that clock. Later changes on `busAd` do not alter the first beat address, which is the captured address with bits 1:0 cleared.
- R3: On a hit, `tgtSelect` stays low in the clock after the address phase and is high from the second clock after it.
- R4: A transaction is a miss and never raises `tgtSelect` if any of these holds: the command is neither memory read (4'b0110) nor memory write (4'b0111); the address differs from `baseAddr` in any bit at or above bit WIN_BITS (12 by default); or `memEnable` is low in the clock after the address phase.
- R5: `tgtReady` is high only while selected and `beReady` is high. A beat completes (`beBeat`) only when `initReady` and `tgtReady` are both high. While `beReady` is low, `beAddr` holds.
- R6: `beAddr` advances by 4 bytes after each completed beat that is not the last, so beat n of a burst uses start + 4n.
- R7: A beat that completes while `busCycle` is low is the last. In the following clock, `tgtSelect` and `tgtReady` are low.
- R8: With SINGLE_ONLY = 1, `tgtStop` is high with `tgtSelect`. After the first completed beat, `tgtSelect` drops in the next clock, even if `busCycle` is still high.
- R9: During a write data beat, `beWrite` is high, `beWrData` equals `busAd` and `beByteEn` equals `busByteEn`. During a read data beat, `busRdData` equals `beRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memEnable | input | 1 | Memory response enable |
| baseAddr | input | 32 | Window base; bits below WIN_BITS ignored |
| busCycle | input | 1 | Initiator transaction framing, high while more beats follow |
| initReady | input | 1 | Initiator ready for the current beat |
| busAd | input | 32 | Address in address phase, write data in data phases |
| busCmd | input | 4 | Command, sampled in the address phase |
| busByteEn | input | 4 | Byte enables during data phases |
| tgtSelect | output | 1 | Transaction claimed |
| tgtReady | output | 1 | Target ready for the current beat |
| tgtStop | output | 1 | Disconnect request (single-beat build) |
| busRdData | output | 32 | Read data toward the bus |
| beAddr | output | 32 | Current beat address |
| beWrData | output | 32 | Write data to the backend |
| beByteEn | output | 4 | Byte enables to the backend |
| beWrite | output | 1 | Write beat offered to the backend |
| beRead | output | 1 | Read beat offered to the backend |
| beBeat | output | 1 | Beat completes at the next edge |
| beRdData | input | 32 | Read data from the backend |
| beReady | input | 1 | Backend ready; low inserts wait states |

## Verification
A table of transactions runs through the burst build:
- single-beat reads;
- a four-beat write burst;
- a three-beat read with two wait states per beat;
- a write that starts from an unaligned address with one wait state;
- four misses, one for each of the following: above the window, below it, a non-memory command, and memory access disabled.

Driving junk on the address lines during the decode clock shows whether the address is captured at the address phase rather than later. Wait-state cases show whether the beat address stalls instead of stepping. The miss rows show which decode condition blocks the claim. A second instance built for single beats is driven with a burst-length request, which tells a real disconnect apart from normal burst termination. A reset during a data phase checks that the claim is dropped at once.

// File: rtl/btt_pkg.sv
package btt_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_DATA   = 2'd2,
    ST_DRAIN  = 2'd3
  } tgt_state_t;

  typedef struct packed {
    logic latchAddr;
    logic stepAddr;
    logic dataPhase;
  } ctl_strobe_t;
endpackage

// File: rtl/btt_control.sv
module btt_control
  import btt_pkg::*;
#(
  parameter bit SINGLE_ONLY = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busCycle,
  input  logic        initReady,
  input  logic        beReady,
  input  logic        hit,
  output ctl_strobe_t strobe,
  output logic        tgtSelect,
  output logic        tgtReady,
  output logic        tgtStop,
  output logic        beBeat
);
  tgt_state_t state, nextState;
  logic inData, beatDone, lastBeat;

  assign inData   = (state == ST_DATA);
  assign tgtSelect = inData;
  assign tgtReady = inData & beReady;
  assign beatDone = tgtReady & initReady;
  assign beBeat   = beatDone;

  generate
    if (SINGLE_ONLY) begin : gSingle
      assign lastBeat = 1'b1;
      assign tgtStop  = inData;
    end else begin : gBurst
      assign lastBeat = ~busCycle;
      assign tgtStop  = 1'b0;
    end
  endgenerate

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (busCycle) begin
          strobe.latchAddr = 1'b1;
          nextState = ST_DECODE;
        end
      end
      ST_DECODE: nextState = hit ? ST_DATA : ST_DRAIN;
      ST_DATA: begin
        strobe.dataPhase = 1'b1;
        if (beatDone) begin
          if (lastBeat) nextState = busCycle ? ST_DRAIN : ST_IDLE;
          else          strobe.stepAddr = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!busCycle && !initReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/btt_datapath.sv
module btt_datapath
  import btt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strobe,
  input  logic                memEnable,
  input  logic                initReady,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [DATA_W-1:0]   busAd,
  input  logic [3:0]          busCmd,
  input  logic [DATA_W/8-1:0] busByteEn,
  input  logic [DATA_W-1:0]   beRdData,
  output logic                hit,
  output logic [DATA_W-1:0]   busRdData,
  output logic [ADDR_W-1:0]   beAddr,
  output logic [DATA_W-1:0]   beWrData,
  output logic [DATA_W/8-1:0] beByteEn,
  output logic                beWrite,
  output logic                beRead
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BE_W);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(BE_W - 1);

  logic [ADDR_W-1:0] addrCnt;
  logic [3:0]        cmdLat;
  logic              isMemCmd, isWrite, inWindow;
  logic [ADDR_W-1:0] addrDiff, busAddr;

  assign busAddr = ADDR_W'(busAd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      cmdLat  <= '0;
    end else if (strobe.latchAddr) begin
      addrCnt <= busAddr & ~ALIGN_MASK;
      cmdLat  <= busCmd;
    end else if (strobe.stepAddr) begin
      addrCnt <= addrCnt + STEP;
    end
  end

  assign isMemCmd = (cmdLat == CMD_MEM_RD) || (cmdLat == CMD_MEM_WR);
  assign isWrite  = (cmdLat == CMD_MEM_WR);
  assign addrDiff = (addrCnt ^ baseAddr) >> WIN_BITS;
  assign inWindow = (addrDiff == '0);
  assign hit      = memEnable & isMemCmd & inWindow;

  assign beAddr   = addrCnt;
  assign beWrData = busAd;
  assign beWrite  = strobe.dataPhase & isWrite & initReady;
  assign beRead   = strobe.dataPhase & ~isWrite & initReady;

  for (genvar lane = 0; lane < BE_W; lane++) begin : gLane
    assign beByteEn[lane] = busByteEn[lane] & strobe.dataPhase;
    assign busRdData[lane*8 +: 8] =
      (strobe.dataPhase & ~isWrite) ? beRdData[lane*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/burst_target_tracker.sv
module burst_target_tracker
  import btt_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter bit SINGLE_ONLY = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                memEnable,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic                busCycle,
  input  logic                initReady,
  input  logic [DATA_W-1:0]   busAd,
  input  logic [3:0]          busCmd,
  input  logic [DATA_W/8-1:0] busByteEn,
  output logic                tgtSelect,
  output logic                tgtReady,
  output logic                tgtStop,
  output logic [DATA_W-1:0]   busRdData,
  output logic [ADDR_W-1:0]   beAddr,
  output logic [DATA_W-1:0]   beWrData,
  output logic [DATA_W/8-1:0] beByteEn,
  output logic                beWrite,
  output logic                beRead,
  output logic                beBeat,
  input  logic [DATA_W-1:0]   beRdData,
  input  logic                beReady
);
  localparam int BEAT_BYTES = DATA_W / 8;

  ctl_strobe_t strobe;
  logic        hit;

  btt_control #(.SINGLE_ONLY(SINGLE_ONLY)) uCtl (
    .clk(clk), .rstN(rstN), .busCycle(busCycle), .initReady(initReady),
    .beReady(beReady), .hit(hit), .strobe(strobe), .tgtSelect(tgtSelect),
    .tgtReady(tgtReady), .tgtStop(tgtStop), .beBeat(beBeat)
  );

  btt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memEnable(memEnable),
    .initReady(initReady), .baseAddr(baseAddr), .busAd(busAd),
    .busCmd(busCmd), .busByteEn(busByteEn), .beRdData(beRdData), .hit(hit),
    .busRdData(busRdData), .beAddr(beAddr), .beWrData(beWrData),
    .beByteEn(beByteEn), .beWrite(beWrite), .beRead(beRead)
  );
endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              memEnable,
  input logic              busCycle,
  input logic              tgtSelect,
  input logic              tgtReady,
  input logic              tgtStop,
  input logic              beBeat,
  input logic [ADDR_W-1:0] beAddr
);
  AST_READY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    tgtReady |-> tgtSelect); // R5

  AST_STALL_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (tgtSelect && !beBeat) |=> $stable(beAddr)); // R5

  AST_BEAT_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (beBeat && busCycle && !tgtStop) |=> (beAddr == $past(beAddr) + ADDR_W'(STEP))); // R6

  AST_CLAIM_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtSelect) |-> $past(busCycle, 2)); // R3

  AST_CLAIM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtSelect) |-> $past(memEnable)); // R4

  AST_LAST_BEAT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (beBeat && !busCycle) |=> (!tgtSelect && !tgtReady)); // R7

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (beBeat && tgtStop) |=> !tgtSelect); // R8
endmodule

bind burst_target_tracker btt_checker #(.ADDR_W(ADDR_W), .STEP(BEAT_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .memEnable(memEnable), .busCycle(busCycle),
  .tgtSelect(tgtSelect), .tgtReady(tgtReady), .tgtStop(tgtStop),
  .beBeat(beBeat), .beAddr(beAddr)
);

// File: tb/sim_burst_target_tracker.sv
`timescale 1ns/1ps
module sim_burst_target_tracker;
  import btt_pkg::*;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic        en;
    logic [3:0]  beats;
    logic [1:0]  waits;
    logic        hit;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0001_0000, CMD_MEM_RD, 1'b1, 4'd1, 2'd0, 1'b1},
    '{32'h0001_0100, CMD_MEM_WR, 1'b1, 4'd4, 2'd0, 1'b1},
    '{32'h0001_0FF0, CMD_MEM_RD, 1'b1, 4'd3, 2'd2, 1'b1},
    '{32'h0001_1000, CMD_MEM_RD, 1'b1, 4'd2, 2'd0, 1'b0},
    '{32'h0000_FFFC, CMD_MEM_WR, 1'b1, 4'd1, 2'd0, 1'b0},
    '{32'h0001_0200, 4'b0010,    1'b1, 4'd1, 2'd0, 1'b0},
    '{32'h0001_0300, CMD_MEM_RD, 1'b0, 4'd2, 2'd0, 1'b0},
    '{32'h0001_0AB6, CMD_MEM_WR, 1'b1, 4'd2, 2'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memEnable = 1'b0;
  logic busCycle = 1'b0;
  logic initReady = 1'b0;
  logic [31:0] busAd = '0;
  logic [3:0] busCmd = '0;
  logic [3:0] busByteEn = '0;
  logic beReady = 1'b0;

  logic selA, rdyA, stopA, wrA, rdA, beatA;
  logic [31:0] rdDataA, addrA, wdA;
  logic [3:0] beA;
  logic selB, rdyB, stopB, wrB, rdB, beatB;
  logic [31:0] rdDataB, addrB, wdB;
  logic [3:0] beB;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_target_tracker u0 (
    .clk(clk), .rstN(rstN), .memEnable(memEnable), .baseAddr(32'h0001_0123),
    .busCycle(busCycle), .initReady(initReady), .busAd(busAd), .busCmd(busCmd),
    .busByteEn(busByteEn), .tgtSelect(selA), .tgtReady(rdyA), .tgtStop(stopA),
    .busRdData(rdDataA), .beAddr(addrA), .beWrData(wdA), .beByteEn(beA),
    .beWrite(wrA), .beRead(rdA), .beBeat(beatA), .beRdData(~addrA),
    .beReady(beReady)
  );

  burst_target_tracker #(.SINGLE_ONLY(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .memEnable(memEnable), .baseAddr(32'h0002_0000),
    .busCycle(busCycle), .initReady(initReady), .busAd(busAd), .busCmd(busCmd),
    .busByteEn(busByteEn), .tgtSelect(selB), .tgtReady(rdyB), .tgtStop(stopB),
    .busRdData(rdDataB), .beAddr(addrB), .beWrData(wdB), .beByteEn(beB),
    .beWrite(wrB), .beRead(rdB), .beBeat(beatB), .beRdData(~addrB),
    .beReady(beReady)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    logic [31:0] start;
    start = v.addr & ~32'h3;
    @(negedge clk);
    busCycle = 1'b1; busAd = v.addr; busCmd = v.cmd; memEnable = v.en;
    initReady = 1'b0; beReady = 1'b0; busByteEn = 4'h0;
    @(negedge clk);
    busCycle = (v.beats > 1); busAd = 32'hDEAD_BEEF; initReady = 1'b1;
    #1 chk(selA == 1'b0, "R3 no claim in decode clock", {31'b0, selA}, 32'd0);
    @(negedge clk);
    if (!v.hit) begin
      #1 chk(selA == 1'b0 && rdyA == 1'b0, "R4 miss not claimed", {31'b0, selA}, 32'd0);
      repeat (2) begin
        @(negedge clk);
        #1 chk(selA == 1'b0, "R4 miss stays unclaimed", {31'b0, selA}, 32'd0);
      end
      @(negedge clk);
      busCycle = 1'b0; initReady = 1'b0;
      @(negedge clk);
      return;
    end
    for (int b = 0; b < int'(v.beats); b++) begin
      for (int w = 0; w <= int'(v.waits); w++) begin
        busCycle = (b < int'(v.beats) - 1);
        busAd = 32'hC0DE_0000 + b;
        busByteEn = b[0] ? 4'h3 : 4'hF;
        beReady = (w == int'(v.waits));
        #1;
        if (b == 0 && w == 0)
          chk(selA == 1'b1, "R3 claim two clocks after address", {31'b0, selA}, 32'd1);
        chk(addrA == start + 32'(4 * b), (b == 0) ? "R2 start address" : "R6 beat address",
            addrA, start + 32'(4 * b));
        if (w < int'(v.waits)) begin
          chk(rdyA == 1'b0 && beatA == 1'b0, "R5 wait state", {30'b0, rdyA, beatA}, 32'd0);
        end else begin
          chk(rdyA == 1'b1 && beatA == 1'b1, "R5 beat completes", {30'b0, rdyA, beatA}, 32'd3);
          if (v.cmd == CMD_MEM_WR) begin
            chk(wrA && wdA == 32'hC0DE_0000 + b && beA == busByteEn,
                "R9 write beat", wdA, 32'hC0DE_0000 + b);
          end else begin
            chk(rdA && rdDataA == ~(start + 32'(4 * b)), "R9 read beat",
                rdDataA, ~(start + 32'(4 * b)));
          end
        end
        @(negedge clk);
      end
    end
    busCycle = 1'b0; initReady = 1'b0; beReady = 1'b0;
    #1 chk(selA == 1'b0 && rdyA == 1'b0, $sformatf("R7 release after vector %0d", idx),
           {30'b0, selA, rdyA}, 32'd0);
  endtask

  initial begin
    #1 chk(selA == 1'b0 && rdyA == 1'b0 && beatA == 1'b0 && wrA == 1'b0 && rdA == 1'b0,
           "R1 reset outputs", {27'b0, selA, rdyA, beatA, wrA, rdA}, 32'd0);
    busCycle = 1'b1; busCmd = CMD_MEM_RD; busAd = 32'h0001_0000; memEnable = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(selA == 1'b0 && stopB == 1'b0, "R1 held in reset", {30'b0, selA, stopB}, 32'd0);
    busCycle = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R8: single-beat build disconnects a burst request after one beat
    @(negedge clk);
    busCycle = 1'b1; busAd = 32'h0002_0040; busCmd = CMD_MEM_RD; memEnable = 1'b1;
    initReady = 1'b0; beReady = 1'b0;
    @(negedge clk);
    busAd = 32'h0; initReady = 1'b1;
    @(negedge clk);
    beReady = 1'b1;
    #1 chk(selB && stopB && beatB, "R8 stop with first beat", {29'b0, selB, stopB, beatB}, 32'd7);
    chk(rdDataB == ~32'h0002_0040, "R9 single read data", rdDataB, ~32'h0002_0040);
    chk(selA == 1'b0, "R4 other window not claimed", {31'b0, selA}, 32'd0);
    @(negedge clk);
    #1 chk(selB == 1'b0 && beatB == 1'b0, "R8 released while cycle still open",
           {30'b0, selB, beatB}, 32'd0);
    busCycle = 1'b0; initReady = 1'b0; beReady = 1'b0;
    @(negedge clk);
    #1 chk(selB == 1'b0, "R8 stays released", {31'b0, selB}, 32'd0);

    // R1: reset during a data phase drops the claim at once
    @(negedge clk);
    busCycle = 1'b1; busAd = 32'h0001_0010; busCmd = CMD_MEM_WR;
    @(negedge clk);
    initReady = 1'b1;
    @(negedge clk);
    #1 chk(selA == 1'b1, "R3 claim before reset", {31'b0, selA}, 32'd1);
    rstN = 1'b0;
    #0.5 chk(selA == 1'b0 && wrA == 1'b0, "R1 async reset mid-burst", {30'b0, selA, wrA}, 32'd0);
    busCycle = 1'b0; initReady = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    done = 1'b1;
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule